// File: doc/BRIEF.md
# Constant-On-Time Step-Down Switch Sequencer

This block is the digital switch sequencer of a hysteretic, constant-on-time step-down converter. Comparator results arrive already digitized: output below regulation, over-current, inductor current above the current-limit enable level, zero inductor current, under-voltage lockout, thermal shutdown and a battery-low flag. From these inputs the block drives the high-side and low-side switch enables and reports which phase the loop is in.

A charge phase begins when the output drops below regulation. The charge phase then lasts for at least a programmed minimum on-time, and longer if the output stays low. This allows the duty cycle to reach 100%. A normal end of charge blanks the comparator for a programmed time. An over-current end forces a longer programmed off-time. After either one, the loop waits in discharge until the output drops again, which gives pulse-frequency operation at light load. A fault opens both switches. Every change between charge and discharge inserts a programmed dead-time.

Top module: `cot_buck_seq`

## Requirements
- R1: While reset is held, mode reads 0 (idle) and both enables are low. One clock edge after reset is released with no fault present, mode reads 4 (wait).
- R2: In wait (mode 4), a synchronized output-low flag with no effective over-current moves the loop to charge (mode 1) on the next edge. An effective over-current (over-current and current-above both high) prevents the start.
- R3: A charge phase lasts at least `ton_cyc_i`+1 cycles. When the output-low flag is already clear, it lasts exactly that many cycles.
- R4: While the output-low flag stays high, charge continues without limit and the high-side enable stays on (100% duty).
- R5: A normal end of charge enters blanking (mode 2) for exactly `blank_cyc_i`+1 cycles and then returns to wait. No charge starts from blanking.
- R6: An effective over-current during charge ends it on the next edge. The loop then enters the over-current off-time (mode 3) for exactly `ocoff_cyc_i`+1 cycles, then wait, and the comparator decides again.
- R7: While current-above is low, the over-current flag has no effect.
- R8: Under-voltage or thermal-shutdown forces mode 0 with both enables low for as long as either is present. Afterwards the loop re-enters wait with the low side off.
- R9: The battery-low output follows the synchronized battery-low flag, except during a lockout, when it is forced low.
- R10: The two enables are never high together. After every entry into charge, blanking or over-current off-time, both stay low for `dead_cyc_i` cycles.
- R11: A zero-current flag during blanking, off-time or wait releases the low-side enable until the next charge ends.
- R12: In wait with the output-low flag low, the loop stays in mode 4 indefinitely, and the low side keeps its state.
- R13: Every flag passes through two synchronizing flops, so a flag change at the inputs moves the mode on the third clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| out_low_i | input | 1 | Output below regulation (comparator) |
| ovc_i | input | 1 | Peak over-current comparator |
| cur_above_i | input | 1 | Inductor current above the current-limit enable level |
| uvlo_i | input | 1 | Under-voltage lockout |
| tsd_i | input | 1 | Thermal shutdown |
| zero_cur_i | input | 1 | Inductor current reached zero |
| batt_low_i | input | 1 | Battery-low comparator |
| ton_cyc_i | input | CNT_W | Minimum on-time in cycles |
| blank_cyc_i | input | CNT_W | Blanking time in cycles |
| ocoff_cyc_i | input | CNT_W | Over-current off-time in cycles |
| dead_cyc_i | input | CNT_W | Dead-time in cycles |
| hs_en_o | output | 1 | High-side switch enable |
| ls_en_o | output | 1 | Low-side switch enable |
| batt_low_o | output | 1 | Battery-low indication, forced low in lockout |
| mode_o | output | 3 | 0 idle/fault, 1 charge, 2 blanking, 3 over-current off, 4 wait |

## Verification
The bench measures whole pulses. It counts the charge, blanking and off-time cycles after a single-cycle output-low pulse. A timer off by one would give a charge of `ton_cyc_i` or `ton_cyc_i`+2 cycles, and the bench flags either. It holds the output low for a long stretch to catch a design that drops the high side when the minimum on-time expires instead of honouring 100% duty. It raises the over-current flag with current-above low and with current-above high. A design without the enable gating would go to off-time in the first case. A design that ignores over-current at the start would begin a charge in the second. Lockout during a live charge, zero current during discharge and the three-edge synchronizer latency are also probed, together with the dead-time gaps, which a design that swapped the switches in one cycle would collapse.

// File: rtl/cot_pkg.sv
package cot_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_CHARGE = 3'd1,
        ST_BLANK  = 3'd2,
        ST_OCOFF  = 3'd3,
        ST_WAIT   = 3'd4
    } cot_state_e;

    localparam int FLAG_N = 7;
    localparam int F_OL   = 0;
    localparam int F_OVC  = 1;
    localparam int F_CUR  = 2;
    localparam int F_UVLO = 3;
    localparam int F_TSD  = 4;
    localparam int F_ZC   = 5;
    localparam int F_BATT = 6;

endpackage

// File: rtl/cot_sync.sv
module cot_sync #(
    parameter int WIDTH  = 1,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);

    logic [STAGES-1:0][WIDTH-1:0] stg_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= {stg_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];

endmodule

// File: rtl/cot_core.sv
module cot_core
    import cot_pkg::*;
#(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ol_i,
    input  logic             ovc_i,
    input  logic             cur_i,
    input  logic             uvlo_i,
    input  logic             tsd_i,
    input  logic             zc_i,
    input  logic             batt_i,
    input  logic [CNT_W-1:0] ton_i,
    input  logic [CNT_W-1:0] blank_i,
    input  logic [CNT_W-1:0] ocoff_i,
    input  logic [CNT_W-1:0] dead_i,
    output logic             hs_o,
    output logic             ls_o,
    output logic             batt_o,
    output logic [2:0]       mode_o
);

    typedef struct packed {
        cot_state_e       st;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] dt;
        logic             ls_act;
        logic             gate_prev;
    } core_regs_t;

    core_regs_t r_d, r_q;

    logic lock, ovc_eff, gate, start, discharging;

    assign lock        = uvlo_i | tsd_i;
    assign ovc_eff     = ovc_i & cur_i;
    assign gate        = ol_i & (r_q.st == ST_WAIT) & ~ovc_eff;
    assign start       = gate & ~r_q.gate_prev;
    assign discharging = (r_q.st == ST_BLANK) || (r_q.st == ST_OCOFF) || (r_q.st == ST_WAIT);

    always_comb begin
        r_d           = r_q;
        r_d.gate_prev = gate;
        if (r_q.dt  != '0) r_d.dt  = r_q.dt - 1'b1;
        if (r_q.cnt != '0) r_d.cnt = r_q.cnt - 1'b1;
        if (zc_i && discharging) r_d.ls_act = 1'b0;

        if (lock) begin
            r_d.st     = ST_IDLE;
            r_d.cnt    = '0;
            r_d.dt     = '0;
            r_d.ls_act = 1'b0;
        end else begin
            unique case (r_q.st)
                ST_IDLE: begin
                    r_d.st     = ST_WAIT;
                    r_d.ls_act = 1'b0;
                end
                ST_WAIT: begin
                    if (start) begin
                        r_d.st  = ST_CHARGE;
                        r_d.cnt = ton_i;
                        r_d.dt  = dead_i;
                    end
                end
                ST_CHARGE: begin
                    if (ovc_eff) begin
                        r_d.st     = ST_OCOFF;
                        r_d.cnt    = ocoff_i;
                        r_d.dt     = dead_i;
                        r_d.ls_act = 1'b1;
                    end else if (r_q.cnt == '0 && !ol_i) begin
                        r_d.st     = ST_BLANK;
                        r_d.cnt    = blank_i;
                        r_d.dt     = dead_i;
                        r_d.ls_act = 1'b1;
                    end
                end
                ST_BLANK, ST_OCOFF: begin
                    if (r_q.cnt == '0) r_d.st = ST_WAIT;
                end
                default: r_d.st = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st        <= ST_IDLE;
            r_q.cnt       <= '0;
            r_q.dt        <= '0;
            r_q.ls_act    <= 1'b0;
            r_q.gate_prev <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

    assign hs_o   = (r_q.st == ST_CHARGE) && (r_q.dt == '0);
    assign ls_o   = discharging && r_q.ls_act && (r_q.dt == '0);
    assign batt_o = batt_i & ~lock;
    assign mode_o = r_q.st;

    // R10: switches exclusive
    a_r10_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs_o && ls_o));

    // R8: lockout forces idle
    a_r8_lock_idle: assert property (@(posedge clk) disable iff (!rst_n)
        lock |=> (r_q.st == ST_IDLE));

    // R6: effective over-current ends charge
    a_r6_ocoff_entry: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CHARGE && ovc_eff && !lock) |=> (r_q.st == ST_OCOFF));

    // R3: minimum on-time honoured
    a_r3_min_on: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CHARGE && r_q.cnt != '0 && !ovc_eff && !lock) |=> (r_q.st == ST_CHARGE));

    // R4: output still low keeps charging
    a_r4_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CHARGE && ol_i && !ovc_eff && !lock) |=> (r_q.st == ST_CHARGE));

    // R7: over-current masked while current-above is low
    a_r7_gated: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_CHARGE && ovc_i && !cur_i && !lock) |=> (r_q.st != ST_OCOFF));

    // R5: blanking never starts a charge
    a_r5_blank_no_start: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_BLANK) |=> (r_q.st != ST_CHARGE));

    // R11: zero current releases the low side
    a_r11_zero_release: assert property (@(posedge clk) disable iff (!rst_n)
        (ls_o && zc_i) |=> !ls_o);

endmodule

// File: rtl/cot_buck_seq.sv
module cot_buck_seq
    import cot_pkg::*;
#(
    parameter int CNT_W     = 8,
    parameter int SYNC_STGS = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             out_low_i,
    input  logic             ovc_i,
    input  logic             cur_above_i,
    input  logic             uvlo_i,
    input  logic             tsd_i,
    input  logic             zero_cur_i,
    input  logic             batt_low_i,
    input  logic [CNT_W-1:0] ton_cyc_i,
    input  logic [CNT_W-1:0] blank_cyc_i,
    input  logic [CNT_W-1:0] ocoff_cyc_i,
    input  logic [CNT_W-1:0] dead_cyc_i,
    output logic             hs_en_o,
    output logic             ls_en_o,
    output logic             batt_low_o,
    output logic [2:0]       mode_o
);

    logic [FLAG_N-1:0] raw_flags, syn_flags;

    assign raw_flags[F_OL]   = out_low_i;
    assign raw_flags[F_OVC]  = ovc_i;
    assign raw_flags[F_CUR]  = cur_above_i;
    assign raw_flags[F_UVLO] = uvlo_i;
    assign raw_flags[F_TSD]  = tsd_i;
    assign raw_flags[F_ZC]   = zero_cur_i;
    assign raw_flags[F_BATT] = batt_low_i;

    cot_sync #(.WIDTH(FLAG_N), .STAGES(SYNC_STGS)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_flags),
        .q_o   (syn_flags)
    );

    cot_core #(.CNT_W(CNT_W)) i_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .ol_i    (syn_flags[F_OL]),
        .ovc_i   (syn_flags[F_OVC]),
        .cur_i   (syn_flags[F_CUR]),
        .uvlo_i  (syn_flags[F_UVLO]),
        .tsd_i   (syn_flags[F_TSD]),
        .zc_i    (syn_flags[F_ZC]),
        .batt_i  (syn_flags[F_BATT]),
        .ton_i   (ton_cyc_i),
        .blank_i (blank_cyc_i),
        .ocoff_i (ocoff_cyc_i),
        .dead_i  (dead_cyc_i),
        .hs_o    (hs_en_o),
        .ls_o    (ls_en_o),
        .batt_o  (batt_low_o),
        .mode_o  (mode_o)
    );

endmodule

// File: tb/test_cot_buck_seq.sv
`timescale 1ns/1ps
module test_cot_buck_seq;

    localparam int W = 8;
    localparam int TON = 6, BLANK = 4, TOFF = 10, DEAD = 2;

    logic clk = 1'b0, rst_n = 1'b0;
    logic out_low = 0, ovc = 0, cur = 0, uvlo = 0, tsd = 0, zc = 0, batt = 0;
    logic hs, ls, batt_o;
    logic [2:0] mode;

    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    cot_buck_seq #(.CNT_W(W)) i_cot_buck_seq (
        .clk(clk), .rst_n(rst_n),
        .out_low_i(out_low), .ovc_i(ovc), .cur_above_i(cur), .uvlo_i(uvlo),
        .tsd_i(tsd), .zero_cur_i(zc), .batt_low_i(batt),
        .ton_cyc_i(W'(TON)), .blank_cyc_i(W'(BLANK)), .ocoff_cyc_i(W'(TOFF)),
        .dead_cyc_i(W'(DEAD)),
        .hs_en_o(hs), .ls_en_o(ls), .batt_low_o(batt_o), .mode_o(mode)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference model: flags {batt,zc,tsd,uvlo,cur,ovc,ol}
    logic [6:0] m_s1 = '0, m_s2 = '0;
    int m_st = 0, m_age = 0, m_lim = 0, m_gap = 0;
    bit m_ls = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 = '0; m_s2 = '0; m_st = 0; m_age = 0; m_lim = 0; m_gap = 0; m_ls = 0;
        end else begin
            automatic bit lk  = m_s2[3] | m_s2[4];
            automatic bit oce = m_s2[1] & m_s2[2];
            automatic bit olw = m_s2[0];
            automatic int nst = m_st;
            automatic int ng  = (m_gap > 0) ? m_gap - 1 : 0;
            automatic bit nls = m_ls;
            if (m_s2[5] && m_st >= 2) nls = 0;
            if (lk) begin
                nst = 0; ng = 0; nls = 0;
            end else if (m_st == 0) begin
                nst = 4; nls = 0;
            end else if (m_st == 4) begin
                if (olw && !oce) begin nst = 1; m_lim = TON; ng = DEAD; end
            end else if (m_st == 1) begin
                if (oce) begin nst = 3; m_lim = TOFF; ng = DEAD; nls = 1; end
                else if (m_age >= m_lim && !olw) begin nst = 2; m_lim = BLANK; ng = DEAD; nls = 1; end
            end else begin
                if (m_age >= m_lim) nst = 4;
            end
            m_age = (nst != m_st) ? 0 : m_age + 1;
            m_st = nst; m_gap = ng; m_ls = nls;
            m_s2 = m_s1;
            m_s1 = {batt, zc, tsd, uvlo, cur, ovc, out_low};
        end
    end

    // Per-cycle comparison against the model, away from the active edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R13 mode vs model", int'(mode), m_st);
            chk("R10 hs vs model", int'(hs), int'(m_st == 1 && m_gap == 0));
            chk("R11 ls vs model", int'(ls), int'(m_st >= 2 && m_ls && m_gap == 0));
            chk("R9 batt vs model", int'(batt_o), int'(m_s2[6] & ~(m_s2[3] | m_s2[4])));
        end
    end

    task automatic cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    initial begin
        #(20 * 150000);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int c1, chs, c2, cls2, c3, cx;
        cyc(3);
        chk("R1 reset mode", int'(mode), 0);
        chk("R1 reset hs", int'(hs), 0);
        chk("R1 reset ls", int'(ls), 0);
        rst_n = 1'b1;
        cyc(2);
        chk("R1 wait after reset", int'(mode), 4);

        // R12: idle waiting
        cx = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (mode != 4 || hs) cx++; end
        chk("R12 stays in wait", cx, 0);

        // R2 R3 R5 R10: single pulse
        out_low = 1; cyc(1); out_low = 0;
        c1 = 0; chs = 0; c2 = 0; cls2 = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (mode == 1) c1++;
            if (hs) chs++;
            if (mode == 2) c2++;
            if (mode == 2 && ls) cls2++;
        end
        chk("R2 charge started", int'(c1 > 0), 1);
        chk("R3 charge length", c1, TON + 1);
        chk("R10 hs width after dead", chs, TON + 1 - DEAD);
        chk("R5 blank length", c2, BLANK + 1);
        chk("R10 ls in blank after dead", cls2, BLANK + 1 - DEAD);
        chk("R12 back to wait", int'(mode), 4);
        chk("R12 ls kept in wait", int'(ls), 1);

        // R11: zero current releases low side
        zc = 1; cyc(4);
        chk("R11 ls released in wait", int'(ls), 0);
        out_low = 1; cyc(1); out_low = 0;
        cx = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (ls) cx++; end
        chk("R11 ls never on", cx, 0);
        zc = 0; cyc(4);

        // R13: latency of three edges
        out_low = 1;
        cyc(2); chk("R13 not yet", int'(mode), 4);
        cyc(1); chk("R13 charge on third edge", int'(mode), 1);

        // R4: long hold
        cyc(10);
        cx = 0;
        for (int i = 0; i < 50; i++) begin @(negedge clk); if (mode != 1 || !hs) cx++; end
        chk("R4 100% duty", cx, 0);

        // R6: over-current during charge
        ovc = 1; cur = 1; cyc(1); ovc = 0; cur = 0;
        c3 = 0;
        for (int i = 0; i < 40; i++) begin @(negedge clk); if (mode == 3) c3++; end
        chk("R6 ocoff length", c3, TOFF + 1);
        chk("R6 comparator resumes", int'(mode), 1);
        out_low = 0; cyc(30);
        chk("R6 settles to wait", int'(mode), 4);

        // R7: over-current gated by current-above
        ovc = 1; out_low = 1;
        c3 = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (mode == 3) c3++; end
        chk("R7 no ocoff", c3, 0);
        chk("R7 still charging", int'(mode), 1);
        cur = 1; cyc(40);
        chk("R2 start blocked by ovc", int'(mode), 4);
        chk("R2 hs off when blocked", int'(hs), 0);
        ovc = 0; cur = 0; out_low = 0; cyc(30);

        // R8 R9: lockout
        batt = 1; cyc(5);
        chk("R9 batt passes", int'(batt_o), 1);
        out_low = 1; cyc(10);
        uvlo = 1; cyc(5);
        chk("R8 idle in uvlo", int'(mode), 0);
        chk("R8 hs off", int'(hs), 0);
        chk("R8 ls off", int'(ls), 0);
        chk("R9 batt forced low", int'(batt_o), 0);
        cx = 0;
        for (int i = 0; i < 30; i++) begin @(negedge clk); if (mode != 0) cx++; end
        chk("R8 held in idle", cx, 0);
        uvlo = 0; tsd = 1; cyc(10);
        chk("R8 idle in tsd", int'(mode), 0);
        tsd = 0; out_low = 0; cyc(5);
        chk("R8 wait after fault", int'(mode), 4);
        chk("R8 ls off after fault", int'(ls), 0);
        batt = 0; cyc(5);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule